// File: doc/BRIEF.md
# Multithread Interrupt, Commit and Issue Thread Arbiter

This block sits in the execute stage of a multithreaded in-order core. In every cycle it names three threads: one that may take an interrupt, one that may retire work from the head of its in-flight queue, and one that may send new work to the functional units. Each of the three has its own rotating priority pointer, so the choices do not depend on each other. Eligibility is computed elsewhere and arrives here as per-thread flag vectors.

An interrupt is accepted only when the thread is at an instruction boundary and is not draining. An accepted interrupt takes the outgoing branch path, so nothing commits or issues in that cycle. When the outgoing branch slot is already busy, commit and issue also stand down. A software-visible policy input selects one of three modes. Single-thread mode considers only thread 0. Round-robin mode rotates fairly among the threads. Random mode starts each scan at a position taken from an internal 8-bit LFSR. When the committing thread has an interrupt waiting, the block tells the commit logic to retire only the remaining micro-ops of the current instruction.

Top module: `thread_slot_arbiter`

## Requirements
- R1: After reset all three priority pointers are 0, the LFSR holds 8'hA5, and every valid output is low while no thread is eligible.
- R2: With policy 2'b00 (single-thread), only thread 0 may win any of the three selections. Its flags for other threads have no effect.
- R3: A thread can take an interrupt when irq_pend, at_boundary are set and draining is clear for it. In the multi-thread policies, the interrupt scan starts at the interrupt pointer itself and walks upward cyclically. The winner becomes the new interrupt pointer.
- R4: In a cycle where irq_valid is high, commit_valid and issue_valid are low, and the commit and issue pointers keep their values.
- R5: While branch_busy is high, commit_valid and issue_valid are low and their pointers hold. Interrupt selection is unaffected.
- R6: Under policy 2'b01 or 2'b11 (round-robin), commit picks the first thread with commit_rdy set, scanning cyclically from the commit pointer plus one. The winner becomes the new commit pointer.
- R7: Under round-robin, issue picks the first thread with both thread_active and input_avail set, scanning from the issue pointer plus one. The winner becomes the new issue pointer.
- R8: Under policy 2'b10 (random), the commit and issue scans both start, inclusively, at the LFSR value modulo the thread count. The LFSR advances every cycle out of reset as {q[6:0], q[7]^q[5]^q[4]^q[3]}.
- R9: commit_uop_only is high exactly when commit_valid is high and the committing thread has irq_pend set and draining clear.
- R10: When a selection has no eligible thread, its valid output is low and its thread id output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| policy | input | 2 | 00 single-thread, 01/11 round-robin, 10 random |
| irq_pend | input | N | Per-thread interrupt pending |
| at_boundary | input | N | Per-thread: last commit ended a whole instruction, no memory access in flight |
| draining | input | N | Per-thread drain in progress |
| commit_rdy | input | N | Per-thread: in-flight head can commit |
| thread_active | input | N | Per-thread: thread is not suspended |
| input_avail | input | N | Per-thread: issue input buffer holds work |
| branch_busy | input | 1 | Outgoing branch slot already occupied this cycle |
| irq_valid | output | 1 | An interrupt is taken this cycle |
| irq_tid | output | TW | Thread taking the interrupt |
| commit_valid | output | 1 | A thread is granted commit |
| commit_tid | output | TW | Committing thread |
| commit_uop_only | output | 1 | Committing thread may retire only micro-ops |
| issue_valid | output | 1 | A thread is granted issue |
| issue_tid | output | TW | Issuing thread |

## Verification
A pointer that fails to load or loads the wrong thread does not show at once. It shows in the next cycle where two or more threads compete, as a grant to the wrong thread id. Once the bench keeps every thread eligible, this happens within one cycle. An LFSR that holds the wrong value in random mode shows as a wrong start position as soon as several threads are eligible. A gating fault, where an interrupt or a busy branch slot fails to block commit and issue, shows as a stray valid in the same cycle. Each of these is checked in the cycle it occurs and again through the pointer it leaves behind.

// File: rtl/tsa_pkg.sv
package tsa_pkg;

  typedef enum logic [1:0] {
    POL_SINGLE    = 2'b00,
    POL_ROUND     = 2'b01,
    POL_RANDOM    = 2'b10,
    POL_ROUND_ALT = 2'b11
  } policy_e;

  localparam int unsigned LFSR_W = 8;

  // One step of the 8-bit shift register
  function automatic logic [LFSR_W-1:0] lfsr_step(logic [LFSR_W-1:0] q);
    return {q[6:0], q[7] ^ q[5] ^ q[4] ^ q[3]};
  endfunction

  // Position where a cyclic scan begins.
  // inclusive: begin at ptr itself rather than the thread after it.
  function automatic int unsigned scan_origin(policy_e pol, int unsigned ptr,
                                              int unsigned rnd, int unsigned n,
                                              bit inclusive, bit use_rnd);
    int unsigned o;
    if (pol == POL_SINGLE)                 o = 0;
    else if (use_rnd && pol == POL_RANDOM) o = rnd % n;
    else if (inclusive)                    o = ptr % n;
    else                                   o = (ptr + 1) % n;
    return o;
  endfunction

endpackage

// File: rtl/tsa_lfsr.sv
module tsa_lfsr #(
  parameter logic [7:0] SEED = 8'hA5
) (
  input  logic       clk,
  input  logic       rst,
  output logic [7:0] q
);
  import tsa_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) q <= SEED;
    else     q <= lfsr_step(q);
  end
endmodule

// File: rtl/tsa_scan.sv
module tsa_scan #(
  parameter int N  = 4,
  parameter int TW = 2
) (
  input  logic [N-1:0]  req,
  input  logic [TW-1:0] start,
  output logic          hit,
  output logic [TW-1:0] win
);
  always_comb begin
    hit = 1'b0;
    win = '0;
    for (int k = 0; k < N; k++) begin
      logic [TW-1:0] idx;
      idx = TW'((int'(start) + k) % N);
      if (!hit && req[idx]) begin
        hit = 1'b1;
        win = idx;
      end
    end
  end
endmodule

// File: rtl/tsa_ptr.sv
module tsa_ptr #(
  parameter int TW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] d,
  output logic [TW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/thread_slot_arbiter.sv
module thread_slot_arbiter #(
  parameter int         N    = 4,
  parameter logic [7:0] SEED = 8'hA5,
  localparam int        TW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    policy,
  input  logic [N-1:0]  irq_pend,
  input  logic [N-1:0]  at_boundary,
  input  logic [N-1:0]  draining,
  input  logic [N-1:0]  commit_rdy,
  input  logic [N-1:0]  thread_active,
  input  logic [N-1:0]  input_avail,
  input  logic          branch_busy,
  output logic          irq_valid,
  output logic [TW-1:0] irq_tid,
  output logic          commit_valid,
  output logic [TW-1:0] commit_tid,
  output logic          commit_uop_only,
  output logic          issue_valid,
  output logic [TW-1:0] issue_tid
);
  import tsa_pkg::*;

  localparam int CH_IRQ = 0;
  localparam int CH_CMT = 1;
  localparam int CH_ISS = 2;
  localparam int NCH    = 3;
  localparam logic [N-1:0] FIRST_ONLY = {{(N-1){1'b0}}, 1'b1};

  policy_e pol;
  assign pol = policy_e'(policy);

  logic [7:0] rnd;
  tsa_lfsr #(.SEED(SEED)) u_lfsr (.clk(clk), .rst(rst), .q(rnd));

  // Raw per-channel eligibility before the single-thread mask
  logic [N-1:0] raw_req [NCH];
  assign raw_req[CH_IRQ] = irq_pend & at_boundary & ~draining;
  assign raw_req[CH_CMT] = commit_rdy;
  assign raw_req[CH_ISS] = thread_active & input_avail;

  logic [N-1:0]  req   [NCH];
  logic [TW-1:0] ptr   [NCH];
  logic [TW-1:0] start [NCH];
  logic          hit   [NCH];
  logic [TW-1:0] win   [NCH];
  logic          grant [NCH];

  // Named event wires for the checker
  logic irq_taken;
  logic slot_blocked;
  logic [TW-1:0] irq_ptr, commit_ptr, issue_ptr;

  genvar ch;
  generate
    for (ch = 0; ch < NCH; ch++) begin : g_ch
      localparam bit INCL = (ch == CH_IRQ);
      localparam bit RNDS = (ch != CH_IRQ);

      assign req[ch] = (pol == POL_SINGLE) ? (raw_req[ch] & FIRST_ONLY)
                                           : raw_req[ch];
      assign start[ch] = TW'(scan_origin(pol, int'(ptr[ch]), int'(rnd),
                                         N, INCL, RNDS));

      tsa_scan #(.N(N), .TW(TW)) u_scan (
        .req(req[ch]), .start(start[ch]), .hit(hit[ch]), .win(win[ch]));

      if (ch == CH_IRQ) begin : g_irq_gate
        assign grant[ch] = hit[ch];
      end else begin : g_slot_gate
        assign grant[ch] = hit[ch] && !slot_blocked;
      end

      tsa_ptr #(.TW(TW)) u_ptr (
        .clk(clk), .rst(rst), .load(grant[ch]), .d(win[ch]), .q(ptr[ch]));
    end
  endgenerate

  assign irq_taken    = grant[CH_IRQ];
  assign slot_blocked = irq_taken || branch_busy;
  assign irq_ptr      = ptr[CH_IRQ];
  assign commit_ptr   = ptr[CH_CMT];
  assign issue_ptr    = ptr[CH_ISS];

  assign irq_valid    = grant[CH_IRQ];
  assign irq_tid      = grant[CH_IRQ] ? win[CH_IRQ] : '0;
  assign commit_valid = grant[CH_CMT];
  assign commit_tid   = grant[CH_CMT] ? win[CH_CMT] : '0;
  assign issue_valid  = grant[CH_ISS];
  assign issue_tid    = grant[CH_ISS] ? win[CH_ISS] : '0;

  assign commit_uop_only = grant[CH_CMT] && irq_pend[win[CH_CMT]]
                           && !draining[win[CH_CMT]];
endmodule

// File: rtl/tsa_checker.sv
module tsa_checker #(
  parameter int N  = 4,
  parameter int TW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    policy,
  input logic [N-1:0]  irq_pend,
  input logic [N-1:0]  at_boundary,
  input logic [N-1:0]  draining,
  input logic [N-1:0]  commit_rdy,
  input logic [N-1:0]  thread_active,
  input logic [N-1:0]  input_avail,
  input logic          branch_busy,
  input logic          irq_valid,
  input logic [TW-1:0] irq_tid,
  input logic          commit_valid,
  input logic [TW-1:0] commit_tid,
  input logic          commit_uop_only,
  input logic          issue_valid,
  input logic [TW-1:0] issue_tid,
  input logic [TW-1:0] irq_ptr,
  input logic [TW-1:0] commit_ptr,
  input logic [TW-1:0] issue_ptr
);
  p_irq_elig_r3: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> (irq_pend[irq_tid] && at_boundary[irq_tid] && !draining[irq_tid]));

  p_irq_ptr_r3: assert property (@(posedge clk) disable iff (rst)
    irq_valid |=> (irq_ptr == $past(irq_tid)));

  p_irq_blocks_r4: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> (!commit_valid && !issue_valid));

  p_busy_blocks_r5: assert property (@(posedge clk) disable iff (rst)
    branch_busy |-> (!commit_valid && !issue_valid));

  p_cmt_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !commit_valid |=> $stable(commit_ptr));

  p_cmt_elig_r6: assert property (@(posedge clk) disable iff (rst)
    commit_valid |-> commit_rdy[commit_tid]);

  p_cmt_ptr_r6: assert property (@(posedge clk) disable iff (rst)
    commit_valid |=> (commit_ptr == $past(commit_tid)));

  p_iss_elig_r7: assert property (@(posedge clk) disable iff (rst)
    issue_valid |-> (thread_active[issue_tid] && input_avail[issue_tid]));

  p_iss_ptr_r7: assert property (@(posedge clk) disable iff (rst)
    issue_valid |=> (issue_ptr == $past(issue_tid)));

  p_single_r2: assert property (@(posedge clk) disable iff (rst)
    (policy == 2'b00) |-> (irq_tid == '0 && commit_tid == '0 && issue_tid == '0));

  p_uop_r9: assert property (@(posedge clk) disable iff (rst)
    commit_uop_only |-> (commit_valid && irq_pend[commit_tid]));

  p_none_r10: assert property (@(posedge clk) disable iff (rst)
    (commit_rdy == '0) |-> (!commit_valid && commit_tid == '0));
endmodule

bind thread_slot_arbiter tsa_checker #(.N(N), .TW(TW)) u_tsa_checker (
  .clk(clk), .rst(rst), .policy(policy),
  .irq_pend(irq_pend), .at_boundary(at_boundary), .draining(draining),
  .commit_rdy(commit_rdy), .thread_active(thread_active),
  .input_avail(input_avail), .branch_busy(branch_busy),
  .irq_valid(irq_valid), .irq_tid(irq_tid),
  .commit_valid(commit_valid), .commit_tid(commit_tid),
  .commit_uop_only(commit_uop_only),
  .issue_valid(issue_valid), .issue_tid(issue_tid),
  .irq_ptr(irq_ptr), .commit_ptr(commit_ptr), .issue_ptr(issue_ptr));

// File: tb/thread_slot_arbiter_test.sv
module thread_slot_arbiter_test;
  localparam int NT = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] policy = 2'b01;
  logic [NT-1:0] irq_pend = '0, at_boundary = '0, draining = '0;
  logic [NT-1:0] commit_rdy = '0, thread_active = '0, input_avail = '0;
  logic branch_busy = 1'b0;
  logic irq_valid, commit_valid, commit_uop_only, issue_valid;
  logic [1:0] irq_tid, commit_tid, issue_tid;

  always #5 clk = ~clk;

  thread_slot_arbiter uut (
    .clk(clk), .rst(rst), .policy(policy),
    .irq_pend(irq_pend), .at_boundary(at_boundary), .draining(draining),
    .commit_rdy(commit_rdy), .thread_active(thread_active),
    .input_avail(input_avail), .branch_busy(branch_busy),
    .irq_valid(irq_valid), .irq_tid(irq_tid),
    .commit_valid(commit_valid), .commit_tid(commit_tid),
    .commit_uop_only(commit_uop_only),
    .issue_valid(issue_valid), .issue_tid(issue_tid));

  typedef struct {
    int iv; int it; int cv; int ct; int u; int qv; int qt;
    string tag;
  } exp_t;

  exp_t q[$];
  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  // Bench-side reference state
  int m_iptr = 0, m_cptr = 0, m_qptr = 0;
  logic [7:0] m_lfsr = 8'hA5;

  task automatic check(string tag, string what, int act, int expv);
    n_checks++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  // First eligible thread walking upward from org; -1 when none
  function automatic int first_from(logic [NT-1:0] r, int org);
    int p;
    p = org;
    repeat (NT) begin
      if (r[p]) return p;
      p = (p == NT - 1) ? 0 : p + 1;
    end
    return -1;
  endfunction

  task automatic step(input logic [1:0] pol, input logic [NT-1:0] pend,
                      input logic [NT-1:0] bnd, input logic [NT-1:0] drn,
                      input logic [NT-1:0] crdy, input logic [NT-1:0] act,
                      input logic [NT-1:0] avl, input logic bb, input string tag);
    exp_t e;
    logic [NT-1:0] ir, cr, sr;
    int iw, cw, sw, c_org, s_org;
    policy = pol; irq_pend = pend; at_boundary = bnd; draining = drn;
    commit_rdy = crdy; thread_active = act; input_avail = avl; branch_busy = bb;
    ir = pend & bnd & ~drn;
    cr = crdy;
    sr = act & avl;
    if (pol == 2'b00) begin
      ir = ir & 4'b0001; cr = cr & 4'b0001; sr = sr & 4'b0001;
      iw = first_from(ir, 0); c_org = 0; s_org = 0;
    end else begin
      iw = first_from(ir, m_iptr);
      if (pol == 2'b10) begin
        c_org = int'(m_lfsr) % NT; s_org = c_org;
      end else begin
        c_org = (m_cptr + 1) % NT; s_org = (m_qptr + 1) % NT;
      end
    end
    if (iw >= 0 || bb) begin
      cw = -1; sw = -1;
    end else begin
      cw = first_from(cr, c_org);
      sw = first_from(sr, s_org);
    end
    e.iv = (iw >= 0); e.it = (iw >= 0) ? iw : 0;
    e.cv = (cw >= 0); e.ct = (cw >= 0) ? cw : 0;
    e.u  = (cw >= 0) ? int'(pend[cw] && !drn[cw]) : 0;
    e.qv = (sw >= 0); e.qt = (sw >= 0) ? sw : 0;
    e.tag = tag;
    q.push_back(e);
    @(posedge clk);
    if (iw >= 0) m_iptr = iw;
    if (cw >= 0) m_cptr = cw;
    if (sw >= 0) m_qptr = sw;
    m_lfsr = {m_lfsr[6:0], m_lfsr[7] ^ m_lfsr[5] ^ m_lfsr[4] ^ m_lfsr[3]};
    @(negedge clk);
    #1;
  endtask

  // Monitor: compares each cycle's outputs with the queued expectation
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(e.tag, "irq_valid", int'(irq_valid), e.iv);
        check(e.tag, "irq_tid", int'(irq_tid), e.it);
        check(e.tag, "commit_valid", int'(commit_valid), e.cv);
        check(e.tag, "commit_tid", int'(commit_tid), e.ct);
        check(e.tag, "commit_uop_only", int'(commit_uop_only), e.u);
        check(e.tag, "issue_valid", int'(issue_valid), e.qv);
        check(e.tag, "issue_tid", int'(issue_tid), e.qt);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state: nothing eligible, all valids low
    check("R1", "irq_valid", int'(irq_valid), 0);
    check("R1", "commit_valid", int'(commit_valid), 0);
    check("R1", "issue_valid", int'(issue_valid), 0);
    check("R1", "commit_tid", int'(commit_tid), 0);

    // R1/R6/R7: from reset pointers, round-robin starts at thread 1
    step(2'b01, 4'h0, 4'hF, 4'h0, 4'hF, 4'hF, 4'hF, 1'b0, "R1");
    step(2'b01, 4'h0, 4'hF, 4'h0, 4'hF, 4'hF, 4'hF, 1'b0, "R6");
    step(2'b01, 4'h0, 4'hF, 4'h0, 4'hF, 4'hF, 4'hF, 1'b0, "R6");
    step(2'b11, 4'h0, 4'hF, 4'h0, 4'hF, 4'hF, 4'hF, 1'b0, "R6");
    step(2'b01, 4'h0, 4'hF, 4'h0, 4'b1010, 4'b0110, 4'b1100, 1'b0, "R7");
    step(2'b01, 4'h0, 4'hF, 4'h0, 4'b1001, 4'hF, 4'b0011, 1'b0, "R7");
    step(2'b01, 4'h0, 4'hF, 4'h0, 4'b0001, 4'b1000, 4'b1000, 1'b0, "R6");
    // R10: nobody eligible
    step(2'b01, 4'h0, 4'hF, 4'h0, 4'h0, 4'hF, 4'h0, 1'b0, "R10");
    step(2'b01, 4'h0, 4'hF, 4'h0, 4'h0, 4'b0101, 4'b1010, 1'b0, "R10");
    // R3: interrupt scan inclusive from pointer, masks on boundary/drain
    step(2'b01, 4'b0110, 4'hF, 4'h0, 4'hF, 4'hF, 4'hF, 1'b0, "R3");
    step(2'b01, 4'b0110, 4'hF, 4'h0, 4'hF, 4'hF, 4'hF, 1'b0, "R3");
    step(2'b01, 4'b1011, 4'b0111, 4'b0010, 4'hF, 4'hF, 4'hF, 1'b0, "R3");
    step(2'b01, 4'b1001, 4'b1001, 4'h0, 4'hF, 4'hF, 4'hF, 1'b0, "R3");
    // R4: after interrupts, commit/issue pointers must be unchanged
    step(2'b01, 4'h0, 4'hF, 4'h0, 4'hF, 4'hF, 4'hF, 1'b0, "R4");
    // R5: busy branch slot blocks commit and issue, not interrupt
    step(2'b01, 4'h0, 4'hF, 4'h0, 4'hF, 4'hF, 4'hF, 1'b1, "R5");
    step(2'b01, 4'b0100, 4'hF, 4'h0, 4'hF, 4'hF, 4'hF, 1'b1, "R5");
    step(2'b01, 4'h0, 4'hF, 4'h0, 4'hF, 4'hF, 4'hF, 1'b0, "R5");
    // R9: pending interrupt not at boundary -> micro-op-only commit
    step(2'b01, 4'b0010, 4'h0, 4'h0, 4'b0010, 4'hF, 4'hF, 1'b0, "R9");
    step(2'b01, 4'b0010, 4'h0, 4'b0010, 4'b0010, 4'hF, 4'hF, 1'b0, "R9");
    step(2'b01, 4'b1000, 4'h0, 4'h0, 4'b0110, 4'hF, 4'hF, 1'b0, "R9");
    // R2: single-thread policy
    step(2'b00, 4'b1110, 4'hF, 4'h0, 4'b1110, 4'hF, 4'b1110, 1'b0, "R2");
    step(2'b00, 4'hF, 4'hF, 4'h0, 4'hF, 4'hF, 4'hF, 1'b0, "R2");
    step(2'b00, 4'h0, 4'hF, 4'h0, 4'hF, 4'hF, 4'hF, 1'b0, "R2");
    step(2'b00, 4'h0, 4'hF, 4'h0, 4'b1011, 4'b0001, 4'b0001, 1'b0, "R2");
    // R8: random policy, several patterns
    for (int k = 0; k < 12; k++) begin
      step(2'b10, 4'h0, 4'hF, 4'h0, 4'hF, 4'hF, 4'hF, 1'b0, "R8");
      step(2'b10, 4'h0, 4'hF, 4'h0, 4'b0101, 4'hF, 4'b1010, 1'b0, "R8");
    end
    step(2'b01, 4'h0, 4'hF, 4'h0, 4'hF, 4'hF, 4'hF, 1'b0, "R6");
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule